// File: doc/BRIEF.md
# I2C Master/Slave Start-Stop Sequencer

This block connects a chip to a two-wire I2C bus through open-drain drivers. Software sets the mode through a single write strobe. The write carries a master bit, a transmit bit, a bus-busy bit and a pending-clear bit, plus an acknowledge-enable bit, a free-format bit and a bit-count field. The combination of the first four bits decides the action. With the bus free, the block issues a START and shifts out the address byte. With the bus held by the block, it issues a STOP or clocks another byte. It then parks with SCL low and raises an interrupt request after every byte and its acknowledge clock.

A bus monitor watches both lines and keeps a busy flag, whoever drives the bus. When the block is not a master, it listens for its own 7-bit address after each START. On a match it returns an ACK and picks up the transfer direction. In master mode, a data bit that reads back low while it should be high is an arbitration loss. The block then lets go of the bus at once. The transmit/receive flag is managed by hardware: the R/W bit of an address frame sets it, and a STOP or an arbitration loss clears it.

Top module: `i2c_seq`

## Requirements
- R1: `st_busy` goes to 1 when a START (SDA falls while SCL is high) is seen on the lines and to 0 when a STOP (SDA rises while SCL is high) is seen, whichever device made it.
- R2: A write with master=1, transmit=1, busy=1, pend=1 is a START request. It is acted on only when `st_busy`=0, the engine is idle and the stored acknowledge-enable is already 1; otherwise it is ignored. When acted on, the block makes a START, then sends `tx_byte` MSB first over 8 SCL clocks, then gives a ninth clock with SDA released.
- R3: In master mode, `irq` rises when the ninth (acknowledge) clock of a byte is over, with SCL then held low. The address byte always has 8 data clocks. A later byte has `cfg_bits` data clocks, where the value 0 stands for 8.
- R4: After a master address byte in normal format, `st_xmit` becomes 1 if the R/W bit (bit 0 of the byte) was 0, and 0 if it was 1.
- R5: A write with master=1, transmit=1, busy=0, pend=1 while the block holds the bus after a byte is a STOP request. The block pulls SDA low, releases SCL and releases SDA only once SCL reads high. If another device holds SCL low, SDA stays low until it lets go.
- R6: `st_xmit` is cleared when a STOP is seen on the bus or when arbitration is lost.
- R7: If, in master transmit, SDA is released but reads low while SCL is high, `st_lost` goes to 1, `st_master` to 0, and both line drivers turn off. Any later write clears `st_lost`.
- R8: Not being a master, in normal format, the block compares the 7 address bits after a START with `own_addr`. On a match with acknowledge-enable set, it pulls SDA low for the ninth clock, sets `st_xmit` to the R/W bit and raises `irq`. On a mismatch it does none of these.
- R9: With the free-format bit set, the first byte after START is data. A master leaves `st_xmit` unchanged after it, and the slave side neither acknowledges nor raises `irq`.
- R10: In master receive (`st_xmit`=0), the block releases SDA for the data bits and collects them MSB first in `rx_byte`. In the ninth clock it pulls SDA low if acknowledge-enable is 1 and releases it if it is 0.
- R11: A write with pend=1 clears `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_master | input | 1 | Master bit of the write |
| cfg_xmit | input | 1 | Transmit bit of the write |
| cfg_busy | input | 1 | Bus-busy bit of the write |
| cfg_pend | input | 1 | Pending-clear bit of the write |
| cfg_acken | input | 1 | Acknowledge enable, stored on every write |
| cfg_free | input | 1 | Free-data format, stored on every write |
| cfg_bits | input | 3 | Data clocks per byte, 0 means 8, stored on every write |
| tx_byte | input | 8 | Byte to send (address and R/W for the first byte) |
| own_addr | input | 7 | Slave address of this block |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drv_low | output | 1 | Pull SCL low |
| sda_drv_low | output | 1 | Pull SDA low |
| st_master | output | 1 | Block is bus master |
| st_xmit | output | 1 | Transmit/receive direction flag |
| st_busy | output | 1 | Bus-busy flag |
| st_lost | output | 1 | Arbitration was lost |
| irq | output | 1 | Byte-complete interrupt request |
| rx_byte | output | 8 | Bits shifted in during the last master byte |

## Verification
The assertions check several properties on every cycle. A write made while the bus is busy never makes the block a master. The block's master SDA driver is only let go at the end of a STOP when SCL reads high. A master interrupt only appears with SCL held low. An arbitration loss leaves both drivers off and the direction flag clear. The byte contents and bit order, the bit-count and format variants, and the direction chosen by each R/W value can only be shown by the bench's scenarios. The same holds for address matching over the full 7-bit space, acknowledge levels and a STOP held back by a stretched SCL. The bench drives these as a modelled peer on the wired-AND lines.

// File: rtl/i2c_seq.sv
module i2c_seq #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_master,
  input  logic       cfg_xmit,
  input  logic       cfg_busy,
  input  logic       cfg_pend,
  input  logic       cfg_acken,
  input  logic       cfg_free,
  input  logic [2:0] cfg_bits,
  input  logic [7:0] tx_byte,
  input  logic [6:0] own_addr,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drv_low,
  output logic       sda_drv_low,
  output logic       st_master,
  output logic       st_xmit,
  output logic       st_busy,
  output logic       st_lost,
  output logic       irq,
  output logic [7:0] rx_byte
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  typedef enum logic [2:0] {M_IDLE, M_START, M_BIT, M_HOLD, M_STOP} mst_e;

  mst_e        st;
  logic [1:0]  q;
  logic [3:0]  bitn, nbits;
  logic [7:0]  shreg, sreg;
  logic [CW-1:0] dcnt;
  logic        m_scl, m_sda, s_sda, addr_ph;
  logic        acken, free;
  logic [1:0]  s_st;
  logic [3:0]  scnt;
  logic        p_scl, r_scl, p_sda, r_sda;

  wire tick      = (dcnt == CW'(DIV - 1));
  wire start_det = p_scl & r_scl & p_sda & ~r_sda;
  wire stop_det  = p_scl & r_scl & ~p_sda & r_sda;
  wire scl_rise  = ~p_scl & r_scl;
  wire scl_fall  = p_scl & ~r_scl;

  wire start_req = cfg_we & cfg_master & cfg_xmit & cfg_busy & cfg_pend & ~st_busy & acken & (st == M_IDLE);
  wire stop_req  = cfg_we & cfg_master & cfg_xmit & ~cfg_busy & cfg_pend & (st == M_HOLD);
  wire next_req  = cfg_we & cfg_master & cfg_busy & cfg_pend & (st == M_HOLD);

  wire last      = (bitn == nbits);
  wire samp      = (st == M_BIT) && tick && (q == 2'd3) && scl_in;
  wire arb       = samp && !last && st_xmit && !m_sda && !sda_in;
  wire m_done    = samp && last;
  wire stop_done = (st == M_STOP) && tick && (q == 2'd2) && scl_in;

  wire s_end = (s_st == 2'd1) && scl_fall && (scnt == 4'd8);
  wire s_hit = s_end && !free && acken && (sreg[7:1] == own_addr);

  assign scl_drv_low = m_scl;
  assign sda_drv_low = m_sda | s_sda;
  assign rx_byte     = shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {p_scl, r_scl, p_sda, r_sda} <= 4'hF;
    else begin
      {p_scl, r_scl} <= {r_scl, scl_in};
      {p_sda, r_sda} <= {r_sda, sda_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else if (st == M_IDLE || st == M_HOLD || tick) dcnt <= '0;
    else dcnt <= dcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= M_IDLE; q <= 2'd0; bitn <= 4'd0; nbits <= 4'd8; shreg <= 8'd0;
      m_scl <= 1'b0; m_sda <= 1'b0; addr_ph <= 1'b0;
    end else begin
      case (st)
        M_IDLE: if (start_req) begin
          st <= M_START; m_sda <= 1'b1; shreg <= tx_byte;
          bitn <= 4'd0; nbits <= 4'd8; addr_ph <= ~cfg_free; q <= 2'd0;
        end
        M_START: if (tick) begin st <= M_BIT; q <= 2'd0; end
        M_BIT: if (tick) begin
          case (q)
            2'd0: begin m_scl <= 1'b1; q <= 2'd1; end
            2'd1: begin
              m_sda <= last ? (~st_xmit & acken) : (st_xmit & ~shreg[7]);
              q <= 2'd2;
            end
            2'd2: begin m_scl <= 1'b0; q <= 2'd3; end
            default: if (scl_in) begin
              if (arb) begin
                st <= M_IDLE; m_scl <= 1'b0; m_sda <= 1'b0;
              end else if (last) begin
                st <= M_HOLD; m_scl <= 1'b1; q <= 2'd0;
              end else begin
                shreg <= {shreg[6:0], sda_in}; bitn <= bitn + 4'd1; q <= 2'd0;
              end
            end
          endcase
        end
        M_HOLD:
          if (stop_req) begin
            st <= M_STOP; q <= 2'd0;
          end else if (next_req) begin
            st <= M_BIT; q <= 2'd0; bitn <= 4'd0; addr_ph <= 1'b0; shreg <= tx_byte;
            nbits <= (cfg_bits == 3'd0) ? 4'd8 : {1'b0, cfg_bits};
          end
        M_STOP: if (tick) begin
          case (q)
            2'd0: begin m_sda <= 1'b1; q <= 2'd1; end
            2'd1: begin m_scl <= 1'b0; q <= 2'd2; end
            default: if (scl_in) begin m_sda <= 1'b0; st <= M_IDLE; end
          endcase
        end
        default: st <= M_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_st <= 2'd0; scnt <= 4'd0; sreg <= 8'd0; s_sda <= 1'b0;
    end else if (stop_det || st_master) begin
      s_st <= 2'd0; s_sda <= 1'b0;
    end else if (start_det) begin
      s_st <= 2'd1; scnt <= 4'd0;
    end else if (s_st == 2'd1) begin
      if (scl_rise && scnt != 4'd8) begin
        sreg <= {sreg[6:0], r_sda}; scnt <= scnt + 4'd1;
      end else if (s_end) begin
        s_sda <= s_hit; s_st <= s_hit ? 2'd2 : 2'd0;
      end
    end else if (s_st == 2'd2 && scl_fall) begin
      s_sda <= 1'b0; s_st <= 2'd0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_busy <= 1'b0; st_master <= 1'b0; st_xmit <= 1'b0; st_lost <= 1'b0;
      irq <= 1'b0; acken <= 1'b0; free <= 1'b0;
    end else begin
      if (start_det) st_busy <= 1'b1;
      else if (stop_det) st_busy <= 1'b0;

      if (start_req) st_master <= 1'b1;
      else if (arb || stop_done) st_master <= 1'b0;

      if (stop_det || arb) st_xmit <= 1'b0;
      else if (start_req) st_xmit <= 1'b1;
      else if (m_done && addr_ph) st_xmit <= ~shreg[0];
      else if (s_hit) st_xmit <= sreg[0];

      if (arb) st_lost <= 1'b1;
      else if (cfg_we) st_lost <= 1'b0;

      if (m_done || s_hit) irq <= 1'b1;
      else if (cfg_we && cfg_pend) irq <= 1'b0;

      if (cfg_we) begin acken <= cfg_acken; free <= cfg_free; end
    end
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic scl_in,
  input logic scl_drv_low,
  input logic sda_drv_low,
  input logic st_master,
  input logic st_xmit,
  input logic st_busy,
  input logic st_lost,
  input logic irq
);
  a_r2_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && st_busy && !st_master) |=> !st_master);

  a_r3_irq_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && st_master) |-> scl_drv_low);

  a_r5_stop_after_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_master) && $fell(sda_drv_low)) |-> $past(scl_in));

  a_r7_lost_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_lost) |-> (!scl_drv_low && !sda_drv_low && !st_master));

  a_r6_lost_clears_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_lost) |-> !st_xmit);
endmodule

bind i2c_seq i2c_seq_chk u_chk (.*);

// File: tb/tb_i2c_seq.sv
module tb_i2c_seq;
  localparam int Q = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_master = 0, cfg_xmit = 0, cfg_busy = 0, cfg_pend = 0;
  logic cfg_acken = 0, cfg_free = 0;
  logic [2:0] cfg_bits = 0;
  logic [7:0] tx_byte = 0;
  logic [6:0] own_addr = 7'h5A;
  logic tb_scl_low = 0, tb_sda_low = 0;
  wire scl_drv_low, sda_drv_low, st_master, st_xmit, st_busy, st_lost, irq;
  wire [7:0] rx_byte;
  wire scl_in = ~(scl_drv_low | tb_scl_low);
  wire sda_in = ~(sda_drv_low | tb_sda_low);
  int nvec = 0, nerr = 0, nstart = 0, nstop = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_seq #(.DIV(2)) dut (.*);

  always @(negedge sda_in) if (scl_in) nstart++;
  always @(posedge sda_in) if (scl_in) nstop++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input bit m, t, b, p, ak, fr, input logic [2:0] bits, input logic [7:0] tx);
    @(negedge clk);
    {cfg_master, cfg_xmit, cfg_busy, cfg_pend, cfg_acken, cfg_free} = {m, t, b, p, ak, fr};
    cfg_bits = bits; tx_byte = tx; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic obs(input int n, input bit drv_ack, output logic [7:0] got, output logic ackb);
    got = 0;
    for (int i = 0; i < n; i++) begin @(posedge scl_in); got = {got[6:0], sda_in}; end
    @(negedge scl_in); tb_sda_low = drv_ack;
    @(posedge scl_in); ackb = sda_in;
    @(negedge scl_in); tb_sda_low = 0;
  endtask

  task automatic ssend(input logic [7:0] b, output logic ackb);
    for (int i = 7; i >= 0; i--) begin
      tb_sda_low = ~b[i]; @(posedge scl_in); @(negedge scl_in);
    end
    tb_sda_low = 0;
    @(posedge scl_in); ackb = sda_in;
    @(negedge scl_in);
  endtask

  task automatic bm_frame(input logic [7:0] b, output logic ackb);
    tb_sda_low = 1; wclk(Q); tb_scl_low = 1; wclk(Q);
    for (int i = 7; i >= 0; i--) begin
      tb_sda_low = ~b[i]; wclk(Q); tb_scl_low = 0; wclk(Q); tb_scl_low = 1; wclk(Q);
    end
    tb_sda_low = 0; wclk(Q); tb_scl_low = 0; wclk(Q); ackb = sda_in; tb_scl_low = 1; wclk(Q);
  endtask

  task automatic bm_stop();
    tb_sda_low = 1; wclk(Q); tb_scl_low = 0; wclk(Q); tb_sda_low = 0; wclk(Q);
  endtask

  task automatic m_stop();
    int ps;
    ps = nstop;
    wr(1, 1, 0, 1, 1, 0, 0, 0);
    wclk(20);
    chk(st_busy == 0, "R1 busy cleared", st_busy, 0);
    chk(nstop == ps + 1, "R5 stop on bus", nstop, ps + 1);
    chk(st_xmit == 0, "R6 xmit cleared by stop", st_xmit, 0);
    chk(irq == 0, "R11 irq cleared by write", irq, 0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nerr++; nvec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic ackb;
    int ps;
    wclk(3); rst_n = 1; wclk(2);
    chk({scl_drv_low, sda_drv_low, st_master, st_xmit, st_busy, st_lost, irq} == 0,
        "R1 reset state", {scl_drv_low, sda_drv_low, st_master, st_xmit, st_busy, st_lost, irq}, 0);

    // R2: start refused while acknowledge-enable not yet stored
    wr(1, 1, 1, 1, 1, 0, 0, 8'hA0);
    wclk(10);
    chk(st_master == 0 && scl_drv_low == 0, "R2 start needs stored ack enable", st_master, 0);

    // R2/R1: start refused while another device holds the bus
    tb_sda_low = 1; wclk(6);
    chk(st_busy == 1, "R1 busy on foreign start", st_busy, 1);
    wr(1, 1, 1, 1, 1, 0, 0, 8'hA0);
    wclk(20);
    chk(st_master == 0 && scl_drv_low == 0, "R2 start ignored when busy", st_master, 0);
    tb_sda_low = 0; wclk(6);
    chk(st_busy == 0, "R1 busy off on foreign stop", st_busy, 0);

    // R2 R3 R4: master address sweep
    for (int a = 0; a < 128; a++)
      for (int rw = 0; rw < 2; rw++) begin
        ps = nstart;
        fork
          wr(1, 1, 1, 1, 1, 0, 0, {a[6:0], rw[0]});
          obs(8, 1, got, ackb);
        join
        wclk(3);
        chk(got == {a[6:0], rw[0]}, "R2 address bits", got, {a[6:0], rw[0]});
        chk(nstart == ps + 1, "R2 start on bus", nstart, ps + 1);
        chk(irq == 1 && scl_drv_low == 1, "R3 irq after ack clock", irq, 1);
        chk(st_xmit == !rw[0], "R4 direction from R/W", st_xmit, !rw[0]);
        chk(st_busy == 1, "R1 busy during frame", st_busy, 1);
        m_stop();
      end

    // R3: bit count field on a data byte
    fork wr(1, 1, 1, 1, 1, 0, 0, 8'h20); obs(8, 1, got, ackb); join
    fork wr(1, 0, 1, 1, 1, 0, 3'd3, 8'hA0); obs(3, 1, got, ackb); join
    wclk(3);
    chk(got[2:0] == 3'b101, "R3 three data clocks", got[2:0], 3'b101);
    chk(irq == 1, "R3 irq after short byte", irq, 1);
    fork wr(1, 0, 1, 1, 1, 0, 3'd0, 8'h96); obs(8, 1, got, ackb); join
    wclk(3);
    chk(got == 8'h96, "R3 field 0 gives eight clocks", got, 8'h96);
    m_stop();

    // R10: master receive with and without acknowledge
    fork wr(1, 1, 1, 1, 1, 0, 0, 8'h21); obs(8, 1, got, ackb); join
    wclk(2);
    fork wr(1, 0, 1, 1, 1, 0, 0, 8'h00); ssend(8'hC5, ackb); join
    wclk(3);
    chk(rx_byte == 8'hC5, "R10 received byte", rx_byte, 8'hC5);
    chk(ackb == 0, "R10 master acks", ackb, 0);
    fork wr(1, 0, 1, 1, 0, 0, 0, 8'h00); ssend(8'h3A, ackb); join
    wclk(3);
    chk(rx_byte == 8'h3A, "R10 second byte", rx_byte, 8'h3A);
    chk(ackb == 1, "R10 no ack when disabled", ackb, 1);
    m_stop();

    // R5: stop delayed by stretched SCL
    fork wr(1, 1, 1, 1, 1, 0, 0, 8'h40); obs(8, 1, got, ackb); join
    tb_scl_low = 1; ps = nstop;
    wr(1, 1, 0, 1, 1, 0, 0, 0);
    wclk(30);
    chk(st_busy == 1 && nstop == ps, "R5 stop waits for SCL", nstop, ps);
    chk(sda_drv_low == 1, "R5 SDA held low while waiting", sda_drv_low, 1);
    tb_scl_low = 0; wclk(20);
    chk(st_busy == 0 && nstop == ps + 1, "R5 stop after SCL release", nstop, ps + 1);
    chk(scl_drv_low == 0 && sda_drv_low == 0 && st_master == 0, "R5 lines free", st_master, 0);

    // R7 R6: arbitration loss on first bit
    fork
      wr(1, 1, 1, 1, 1, 0, 0, 8'hFF);
      begin @(negedge scl_in); tb_sda_low = 1; end
    join
    wclk(20);
    chk(st_lost == 1, "R7 lost flag", st_lost, 1);
    chk(st_master == 0, "R7 master dropped", st_master, 0);
    chk(scl_drv_low == 0 && sda_drv_low == 0, "R7 drivers off", {scl_drv_low, sda_drv_low}, 0);
    chk(st_xmit == 0, "R6 xmit cleared on loss", st_xmit, 0);
    tb_sda_low = 0; wclk(6);
    chk(st_busy == 0, "R1 busy off after loss", st_busy, 0);
    wr(0, 0, 0, 1, 1, 0, 0, 0); wclk(2);
    chk(st_lost == 0, "R7 lost cleared by write", st_lost, 0);

    // R9: free format master keeps direction
    wr(0, 0, 0, 1, 1, 1, 0, 0);
    fork wr(1, 1, 1, 1, 1, 1, 0, 8'h01); obs(8, 1, got, ackb); join
    wclk(3);
    chk(st_xmit == 1, "R9 free format keeps direction", st_xmit, 1);
    chk(irq == 1, "R3 irq in free format", irq, 1);
    m_stop();

    // R8: slave address sweep
    wr(0, 0, 0, 1, 1, 0, 0, 0);
    for (int a = 0; a < 128; a++)
      for (int rw = 0; rw < 2; rw++) begin
        bit hit;
        hit = (a == 7'h5A);
        bm_frame({a[6:0], rw[0]}, ackb);
        chk(ackb == !hit, "R8 slave ack level", ackb, !hit);
        chk(irq == hit, "R8 slave irq", irq, hit);
        chk(st_xmit == (hit && rw[0]), "R8 slave direction", st_xmit, hit && rw[0]);
        bm_stop();
        wr(0, 0, 0, 1, 1, 0, 0, 0);
        wclk(2);
        chk(irq == 0, "R11 irq cleared", irq, 0);
      end

    // R8: matching address but acknowledge disabled
    wr(0, 0, 0, 1, 0, 0, 0, 0);
    bm_frame({7'h5A, 1'b1}, ackb);
    chk(ackb == 1 && irq == 0, "R8 no ack when disabled", ackb, 1);
    bm_stop();

    // R9: free format slave ignores matching address
    wr(0, 0, 0, 1, 1, 1, 0, 0);
    bm_frame({7'h5A, 1'b1}, ackb);
    chk(ackb == 1 && irq == 0 && st_xmit == 0, "R9 slave free format", ackb, 1);
    bm_stop();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule